// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the standard 64-byte configuration header of one PCI function. A requester issues one access at a time through a small request port. The access carries a byte offset, a size of 1, 2 or 4 bytes, a write flag and write data. After a fixed, parameterised latency the block returns one response cycle with read data and an error flag. All header fields take their reset values from parameters.

Six base address registers are provided, each with its own size and legacy flag. A normal BAR implements the sizing handshake: software writes all ones, reads back a size mask with the type bits intact, then writes an address. The block exports each BAR's decoded base and an enable, and raises a one-cycle change pulse whenever a base is relocated. A legacy BAR is tied to a fixed base and cannot be written. Elaboration stops with an error if a non-legacy BAR is given a nonzero size that is not a power of two.

The control path is a three-state machine. `ST_IDLE` takes a request and moves to `ST_WAIT` (accept). `ST_WAIT` counts down the latency and holds while the count is nonzero (count). It moves to `ST_DONE` when the count reaches zero (expire). `ST_DONE` presents the response, commits any write, and always returns to `ST_IDLE` (complete).

Top module: `pcfg_header`

## Requirements
- R1: After reset, every header field reads its parameter value. The reserved words at offsets 0x34 and 0x38 read zero. `req_ready` is high, `resp_valid` and `range_changed` are low, and `bar_en` is set only for legacy BARs.
- R2: `req_ready` is high only in `ST_IDLE`. `resp_valid` lasts one cycle and is never high together with `req_ready`. It rises exactly `RESP_LAT`+1 cycles after the cycle in which a request is accepted.
- R3: A read returns the header bytes at `offset`, `offset`+1 and so on, little-endian and zero-extended to 32 bits. A read of size 1 fills bits 7:0, size 2 fills bits 15:0, and size 4 fills bits 31:0. Bytes past offset 0x3F read zero.
- R4: A size other than 1, 2 or 4, or any offset of 0x40 or above, gives `resp_err`=1 and changes no state. For writes, `resp_rdata` is zero.
- R5: 8-bit writes update offsets 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer). They are accepted without effect at 0x3D, 0x3E, 0x3F, 0x0B and 0x08. At any other offset they give `resp_err`.
- R6: A 16-bit write at 0x04 loads the command word and at 0x06 loads the status word. At 0x0C it loads the cache line size from the low byte. At any other offset it gives `resp_err`.
- R7: A 32-bit write at 0x04 loads the command word from bits 15:0 and leaves status unchanged. A 32-bit write to any offset below 0x40 that is not a BAR (0x10 + 4·n) and not the ROM register (0x30) has no effect and no error.
- R8: A 32-bit write of 0xFFFFFFFF to a non-legacy BAR loads ~(size−1) into the address bits and keeps the old type bits. The type mask is 0x3 when the old bit 0 is 1 (I/O) and 0xF otherwise (memory). A size of zero reads back only the type bits.
- R9: Any other 32-bit write to a non-legacy BAR stores the written address bits merged with the old type bits. If those address bits are nonzero, that BAR's `bar_base` takes them and its `bar_en` is set, and `range_changed` pulses in the response cycle. Otherwise `bar_base` keeps its value and no pulse occurs.
- R10: A legacy BAR ignores every write, always reads zero, drives its fixed parameter base on `bar_base`, and keeps its `bar_en` high.
- R11: A 32-bit write of 0xFFFFFFFE to offset 0x30 makes it read 0xFFFFFFFF. Any other 32-bit write there is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, little-endian from bit 0 |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Read data, zero-extended |
| resp_err | output | 1 | Access unsupported or illegal |
| bar_base | output | 6×32 | Decoded base of each BAR, BAR n at bits 32n+31:32n |
| bar_en | output | 6 | Base of each BAR is valid |
| range_changed | output | 1 | A BAR base was relocated |

## Verification
The assertions assume that reset is held for at least one clock edge before traffic starts. They also assume that a request is taken only at an edge where `req_ready` is high, so the latched request cannot change while an access is in flight. The stimulus waits for `req_ready` before raising `req_valid` and drops it at the first falling edge after acceptance. It uses only sizes and offsets chosen on purpose, including the illegal ones, so every response cycle is one the checker expects.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int NUM_BARS  = 6;
    localparam int DW        = 32;
    localparam int HDR_BYTES = 64;
    localparam int HDR_WORDS = HDR_BYTES / 4;

    // header offsets the write decoder depends on
    localparam logic [5:0] OFF_CMD      = 6'h04;
    localparam logic [5:0] OFF_STAT     = 6'h06;
    localparam logic [5:0] OFF_REV      = 6'h08;
    localparam logic [5:0] OFF_CLASS    = 6'h0B;
    localparam logic [5:0] OFF_CLS      = 6'h0C;
    localparam logic [5:0] OFF_LAT      = 6'h0D;
    localparam int         OFF_BAR0     = 16;
    localparam logic [5:0] OFF_ROM      = 6'h30;
    localparam logic [5:0] OFF_INT_LINE = 6'h3C;
    localparam logic [5:0] OFF_INT_PIN  = 6'h3D;
    localparam logic [5:0] OFF_MIN_GNT  = 6'h3E;
    localparam logic [5:0] OFF_MAX_LAT  = 6'h3F;

    localparam logic [DW-1:0] IO_TYPE_MASK  = 32'h0000_0003;
    localparam logic [DW-1:0] MEM_TYPE_MASK = 32'h0000_000F;
    localparam logic [DW-1:0] ROM_PROBE     = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    function automatic logic pow2_or_zero(input logic [DW-1:0] v);
        return (v & (v - 32'd1)) == '0;
    endfunction

endpackage

// File: rtl/pcfg_seq.sv
module pcfg_seq
    import pcfg_pkg::*;
#(
    parameter int RESP_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic done
);

    localparam int CNT_W = (RESP_LAT < 2) ? 1 : $clog2(RESP_LAT);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (accept)          cnt <= CNT_W'(RESP_LAT - 1);
        else if (state == ST_WAIT && cnt != '0) cnt <= cnt - 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_WAIT;      // accept
            ST_WAIT: if (cnt == '0) state_nx = ST_DONE;      // expire, else count
            ST_DONE: state_nx = ST_IDLE;                     // complete
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_WAIT: ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign accept = req_ready && req_valid;

    initial begin
        if (RESP_LAT < 1) $error("RESP_LAT must be at least 1");
    end

endmodule

// File: rtl/pcfg_bar_slot.sv
module pcfg_bar_slot
    import pcfg_pkg::*;
#(
    parameter logic [31:0] BAR_SIZE    = 32'h1000,
    parameter bit          LEGACY      = 1'b0,
    parameter logic [31:0] BAR_INIT    = 32'h0,
    parameter logic [31:0] LEGACY_BASE = 32'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] base,
    output logic          en,
    output logic          changed
);

    localparam logic [DW-1:0] SIZE_MASK = ~(BAR_SIZE - 32'd1);

    generate
        if (!LEGACY && !pow2_or_zero(BAR_SIZE)) begin : g_bad_size
            $error("BAR size must be zero or a power of two");
        end
    endgenerate

    logic [DW-1:0] bar_q, base_q, type_mask, addr_part, bar_nx;
    logic          en_q, wr_eff, sizing;

    assign wr_eff    = wr_go && !LEGACY;
    assign type_mask = bar_q[0] ? IO_TYPE_MASK : MEM_TYPE_MASK;
    assign sizing    = (wdata == '1);
    assign addr_part = wdata & ~type_mask;

    always_comb begin
        if (sizing) bar_nx = (SIZE_MASK & ~type_mask) | (bar_q & type_mask);
        else        bar_nx = addr_part | (bar_q & type_mask);
    end

    assign changed = wr_eff && !sizing && (addr_part != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q  <= BAR_INIT;
            base_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (wr_eff) bar_q <= bar_nx;
            if (changed) begin
                base_q <= addr_part;
                en_q   <= 1'b1;
            end
        end
    end

    assign rd_val = LEGACY ? '0 : bar_q;
    assign base   = LEGACY ? LEGACY_BASE : base_q;
    assign en     = LEGACY ? 1'b1 : en_q;

endmodule

// File: rtl/pcfg_header.sv
module pcfg_header
    import pcfg_pkg::*;
#(
    parameter int                     ADDR_W        = 8,
    parameter int                     RESP_LAT      = 2,
    parameter logic [15:0]            VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0]            DEVICE_ID     = 16'h0A51,
    parameter logic [15:0]            CMD_INIT      = 16'h0000,
    parameter logic [15:0]            STAT_INIT     = 16'h0010,
    parameter logic [7:0]             REV_ID        = 8'h03,
    parameter logic [7:0]             PROG_IF       = 8'h00,
    parameter logic [7:0]             SUB_CLASS     = 8'h80,
    parameter logic [7:0]             BASE_CLASS    = 8'h02,
    parameter logic [7:0]             CLS_INIT      = 8'h00,
    parameter logic [7:0]             LAT_INIT      = 8'h00,
    parameter logic [7:0]             HDR_TYPE      = 8'h00,
    parameter logic [7:0]             SELF_TEST     = 8'h00,
    parameter logic [31:0]            CIS_PTR       = 32'h0,
    parameter logic [15:0]            SUBSYS_VID    = 16'h1111,
    parameter logic [15:0]            SUBSYS_ID     = 16'h2222,
    parameter logic [31:0]            ROM_INIT      = 32'h0,
    parameter logic [7:0]             INT_LINE_INIT = 8'h0B,
    parameter logic [7:0]             INT_PIN       = 8'h01,
    parameter logic [7:0]             MIN_GRANT     = 8'h04,
    parameter logic [7:0]             MAX_LATENCY   = 8'h08,
    parameter logic [NUM_BARS*32-1:0] BAR_SIZES     = {32'h0, 32'h0001_0000, 32'h8,
                                                       32'h0, 32'h100, 32'h1000},
    parameter logic [NUM_BARS*32-1:0] BAR_INITS     = {32'h0, 32'h8, 32'h1F1,
                                                       32'h0, 32'h1, 32'h0},
    parameter logic [NUM_BARS-1:0]    BAR_LEGACY    = 6'b001000,
    parameter logic [NUM_BARS*32-1:0] LEGACY_BASES  = {32'h0, 32'h0, 32'h1F0,
                                                       32'h0, 32'h0, 32'h0}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [2:0]             req_size,
    input  logic [DW-1:0]          req_wdata,
    output logic                   resp_valid,
    output logic [DW-1:0]          resp_rdata,
    output logic                   resp_err,
    output logic [NUM_BARS*32-1:0] bar_base,
    output logic [NUM_BARS-1:0]    bar_en,
    output logic                   range_changed
);

    logic accept, done;

    pcfg_seq #(.RESP_LAT(RESP_LAT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .done      (done)
    );

    // ---------------- latched request ----------------
    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [2:0]        q_size;
    logic [DW-1:0]     q_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_we    <= 1'b0;
            q_addr  <= '0;
            q_size  <= '0;
            q_wdata <= '0;
        end else if (accept) begin
            q_we    <= req_we;
            q_addr  <= req_addr;
            q_size  <= req_size;
            q_wdata <= req_wdata;
        end
    end

    // ---------------- legality ----------------
    logic [5:0] off;
    logic       off_ok, size_ok, wr_bad, err, wr_go;

    assign off     = q_addr[5:0];
    assign off_ok  = (q_addr < ADDR_W'(HDR_BYTES));
    assign size_ok = (q_size == 3'd1) || (q_size == 3'd2) || (q_size == 3'd4);

    always_comb begin
        wr_bad = 1'b0;
        case (q_size)
            3'd1: begin
                case (off)
                    OFF_INT_LINE, OFF_CLS, OFF_LAT,
                    OFF_INT_PIN, OFF_MIN_GNT, OFF_MAX_LAT,
                    OFF_CLASS, OFF_REV: wr_bad = 1'b0;
                    default:            wr_bad = 1'b1;
                endcase
            end
            3'd2: begin
                case (off)
                    OFF_CMD, OFF_STAT, OFF_CLS: wr_bad = 1'b0;
                    default:                    wr_bad = 1'b1;
                endcase
            end
            default: wr_bad = 1'b0;
        endcase
    end

    assign err   = !size_ok || !off_ok || (q_we && wr_bad);
    assign wr_go = done && q_we && !err;

    // ---------------- writable fields ----------------
    logic [15:0] cmd_q, stat_q;
    logic [7:0]  cls_q, lat_q, int_line_q;
    logic [31:0] rom_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_INIT;
            stat_q     <= STAT_INIT;
            cls_q      <= CLS_INIT;
            lat_q      <= LAT_INIT;
            int_line_q <= INT_LINE_INIT;
            rom_q      <= ROM_INIT;
        end else if (wr_go) begin
            case (q_size)
                3'd1: begin
                    case (off)
                        OFF_INT_LINE: int_line_q <= q_wdata[7:0];
                        OFF_CLS:      cls_q      <= q_wdata[7:0];
                        OFF_LAT:      lat_q      <= q_wdata[7:0];
                        default: ;
                    endcase
                end
                3'd2: begin
                    case (off)
                        OFF_CMD:  cmd_q  <= q_wdata[15:0];
                        OFF_STAT: stat_q <= q_wdata[15:0];
                        OFF_CLS:  cls_q  <= q_wdata[7:0];
                        default: ;
                    endcase
                end
                3'd4: begin
                    case (off)
                        OFF_CMD: cmd_q <= q_wdata[15:0];
                        OFF_ROM: rom_q <= (q_wdata == ROM_PROBE) ? '1 : q_wdata;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // ---------------- base address registers ----------------
    logic [DW-1:0]       bar_rd  [NUM_BARS];
    logic [NUM_BARS-1:0] bar_wr, bar_chg;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BARS; gi++) begin : g_bar
            assign bar_wr[gi] = wr_go && (q_size == 3'd4) &&
                                (off == 6'(OFF_BAR0 + 4 * gi));

            pcfg_bar_slot #(
                .BAR_SIZE    (BAR_SIZES[32*gi +: 32]),
                .LEGACY      (BAR_LEGACY[gi]),
                .BAR_INIT    (BAR_INITS[32*gi +: 32]),
                .LEGACY_BASE (LEGACY_BASES[32*gi +: 32])
            ) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_go   (bar_wr[gi]),
                .wdata   (q_wdata),
                .rd_val  (bar_rd[gi]),
                .base    (bar_base[32*gi +: 32]),
                .en      (bar_en[gi]),
                .changed (bar_chg[gi])
            );
        end
    endgenerate

    // ---------------- read path ----------------
    logic [DW-1:0]   hdr_w [HDR_WORDS];
    logic [3:0]      w_idx, w_nx;
    logic [2*DW-1:0] pair;
    logic [2*DW-1:0] shifted;
    logic [DW-1:0]   rd_val;

    always_comb begin
        hdr_w[0]  = {DEVICE_ID, VENDOR_ID};
        hdr_w[1]  = {stat_q, cmd_q};
        hdr_w[2]  = {BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
        hdr_w[3]  = {SELF_TEST, HDR_TYPE, lat_q, cls_q};
        for (int b = 0; b < NUM_BARS; b++) hdr_w[4 + b] = bar_rd[b];
        hdr_w[10] = CIS_PTR;
        hdr_w[11] = {SUBSYS_ID, SUBSYS_VID};
        hdr_w[12] = rom_q;
        hdr_w[13] = '0;
        hdr_w[14] = '0;
        hdr_w[15] = {MAX_LATENCY, MIN_GRANT, INT_PIN, int_line_q};
    end

    assign w_idx   = off[5:2];
    assign w_nx    = w_idx + 4'd1;
    assign pair    = {(w_idx == 4'd15) ? {DW{1'b0}} : hdr_w[w_nx], hdr_w[w_idx]};
    assign shifted = pair >> {off[1:0], 3'b000};

    always_comb begin
        case (q_size)
            3'd1:    rd_val = {24'b0, shifted[7:0]};
            3'd2:    rd_val = {16'b0, shifted[15:0]};
            default: rd_val = shifted[DW-1:0];
        endcase
    end

    // ---------------- response ----------------
    assign resp_valid    = done;
    assign resp_err      = done && err;
    assign resp_rdata    = (done && !q_we && !err) ? rd_val : '0;
    assign range_changed = |bar_chg;

endmodule

// File: rtl/pcfg_header_chk.sv
module pcfg_header_chk
    import pcfg_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   resp_valid,
    input logic                   resp_err,
    input logic [NUM_BARS*32-1:0] bar_base,
    input logic [NUM_BARS-1:0]    bar_en,
    input logic                   range_changed
);

    assert_resp_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_ready_excl_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && resp_valid));

    assert_pulse_in_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        range_changed |-> (resp_valid && !resp_err));

    assert_err_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> !range_changed);

    assert_base_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !range_changed |=> $stable(bar_base));

    assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !range_changed |=> $stable(bar_en));

endmodule

bind pcfg_header pcfg_header_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_err      (resp_err),
    .bar_base      (bar_base),
    .bar_en        (bar_en),
    .range_changed (range_changed)
);

// File: tb/pcfg_header_bench.sv
`timescale 1ns/1ps
module pcfg_header_bench;

    localparam int LAT = 2;

    typedef struct packed {
        logic        we;
        logic [2:0]  sz;
        logic [7:0]  off;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd4, 8'h00, 32'h0,        32'h0A51C0DE, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd1, 8'h0B, 32'h0,        32'h00000002, 1'b0, 8'd3},  // R3
        '{1'b0, 3'd2, 8'h06, 32'h0,        32'h00000010, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd4, 8'h08, 32'h0,        32'h02800003, 1'b0, 8'd3},  // R3
        '{1'b0, 3'd4, 8'h3C, 32'h0,        32'h0804010B, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd4, 8'h34, 32'h0,        32'h00000000, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd4, 8'h38, 32'h0,        32'h00000000, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd4, 8'h14, 32'h0,        32'h00000001, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd4, 8'h20, 32'h0,        32'h00000008, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd4, 8'h1C, 32'h0,        32'h00000000, 1'b0, 8'd10}, // R10
        '{1'b0, 3'd4, 8'h30, 32'h0,        32'h00000000, 1'b0, 8'd1},  // R1
        '{1'b0, 3'd2, 8'h2E, 32'h0,        32'h00002222, 1'b0, 8'd3},  // R3
        '{1'b0, 3'd2, 8'h3F, 32'h0,        32'h00000008, 1'b0, 8'd3},  // R3
        '{1'b0, 3'd2, 8'h01, 32'h0,        32'h000051C0, 1'b0, 8'd3},  // R3
        '{1'b0, 3'd3, 8'h00, 32'h0,        32'h00000000, 1'b1, 8'd4},  // R4
        '{1'b0, 3'd4, 8'h40, 32'h0,        32'h00000000, 1'b1, 8'd4},  // R4
        '{1'b1, 3'd0, 8'h3C, 32'h99,       32'h00000000, 1'b1, 8'd4},  // R4
        '{1'b1, 3'd1, 8'h7C, 32'h99,       32'h00000000, 1'b1, 8'd4},  // R4
        '{1'b0, 3'd1, 8'h3C, 32'h0,        32'h0000000B, 1'b0, 8'd4},  // R4
        '{1'b1, 3'd1, 8'h3C, 32'h5A,       32'h00000000, 1'b0, 8'd5},  // R5
        '{1'b0, 3'd1, 8'h3C, 32'h0,        32'h0000005A, 1'b0, 8'd5},  // R5
        '{1'b1, 3'd1, 8'h3D, 32'h77,       32'h00000000, 1'b0, 8'd5},  // R5
        '{1'b0, 3'd1, 8'h3D, 32'h0,        32'h00000001, 1'b0, 8'd5},  // R5
        '{1'b1, 3'd1, 8'h08, 32'h77,       32'h00000000, 1'b0, 8'd5},  // R5
        '{1'b0, 3'd1, 8'h08, 32'h0,        32'h00000003, 1'b0, 8'd5},  // R5
        '{1'b1, 3'd1, 8'h00, 32'h77,       32'h00000000, 1'b1, 8'd5},  // R5
        '{1'b0, 3'd2, 8'h00, 32'h0,        32'h0000C0DE, 1'b0, 8'd5},  // R5
        '{1'b1, 3'd1, 8'h0D, 32'h20,       32'h00000000, 1'b0, 8'd5},  // R5
        '{1'b1, 3'd2, 8'h04, 32'h0147,     32'h00000000, 1'b0, 8'd6},  // R6
        '{1'b0, 3'd2, 8'h04, 32'h0,        32'h00000147, 1'b0, 8'd6},  // R6
        '{1'b1, 3'd2, 8'h06, 32'h0033,     32'h00000000, 1'b0, 8'd6},  // R6
        '{1'b0, 3'd2, 8'h06, 32'h0,        32'h00000033, 1'b0, 8'd6},  // R6
        '{1'b1, 3'd2, 8'h0C, 32'h3344,     32'h00000000, 1'b0, 8'd6},  // R6
        '{1'b0, 3'd2, 8'h0C, 32'h0,        32'h00002044, 1'b0, 8'd6},  // R6
        '{1'b1, 3'd2, 8'h08, 32'h1,        32'h00000000, 1'b1, 8'd6},  // R6
        '{1'b1, 3'd4, 8'h04, 32'hABCD0006, 32'h00000000, 1'b0, 8'd7},  // R7
        '{1'b0, 3'd4, 8'h04, 32'h0,        32'h00330006, 1'b0, 8'd7},  // R7
        '{1'b1, 3'd4, 8'h00, 32'hFFFFFFFF, 32'h00000000, 1'b0, 8'd7},  // R7
        '{1'b0, 3'd4, 8'h00, 32'h0,        32'h0A51C0DE, 1'b0, 8'd7},  // R7
        '{1'b1, 3'd4, 8'h0C, 32'hFFFFFFFF, 32'h00000000, 1'b0, 8'd7},  // R7
        '{1'b0, 3'd2, 8'h0C, 32'h0,        32'h00002044, 1'b0, 8'd7},  // R7
        '{1'b1, 3'd4, 8'h10, 32'hFFFFFFFF, 32'h00000000, 1'b0, 8'd8},  // R8
        '{1'b0, 3'd4, 8'h10, 32'h0,        32'hFFFFF000, 1'b0, 8'd8},  // R8
        '{1'b1, 3'd4, 8'h14, 32'hFFFFFFFF, 32'h00000000, 1'b0, 8'd8},  // R8
        '{1'b0, 3'd4, 8'h14, 32'h0,        32'hFFFFFF01, 1'b0, 8'd8},  // R8
        '{1'b1, 3'd4, 8'h20, 32'hFFFFFFFF, 32'h00000000, 1'b0, 8'd8},  // R8
        '{1'b0, 3'd4, 8'h20, 32'h0,        32'hFFFF0008, 1'b0, 8'd8},  // R8
        '{1'b1, 3'd4, 8'h18, 32'hFFFFFFFF, 32'h00000000, 1'b0, 8'd8},  // R8
        '{1'b0, 3'd4, 8'h18, 32'h0,        32'h00000000, 1'b0, 8'd8},  // R8
        '{1'b1, 3'd4, 8'h10, 32'h40001237, 32'h00000000, 1'b0, 8'd9},  // R9
        '{1'b0, 3'd4, 8'h10, 32'h0,        32'h40001230, 1'b0, 8'd9},  // R9
        '{1'b1, 3'd4, 8'h14, 32'h0000C0FE, 32'h00000000, 1'b0, 8'd9},  // R9
        '{1'b0, 3'd4, 8'h14, 32'h0,        32'h0000C0FD, 1'b0, 8'd9},  // R9
        '{1'b1, 3'd4, 8'h1C, 32'h12345678, 32'h00000000, 1'b0, 8'd10}, // R10
        '{1'b0, 3'd4, 8'h1C, 32'h0,        32'h00000000, 1'b0, 8'd10}, // R10
        '{1'b1, 3'd4, 8'h30, 32'hFFFFFFFE, 32'h00000000, 1'b0, 8'd11}, // R11
        '{1'b0, 3'd4, 8'h30, 32'h0,        32'hFFFFFFFF, 1'b0, 8'd11}, // R11
        '{1'b1, 3'd4, 8'h30, 32'h000C0001, 32'h00000000, 1'b0, 8'd11}  // R11
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_we = 1'b0;
    logic [7:0]   req_addr = '0;
    logic [2:0]   req_size = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         resp_err;
    logic [191:0] bar_base;
    logic [5:0]   bar_en;
    logic         range_changed;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    pcfg_header #(.RESP_LAT(LAT)) u_pcfg_header (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_we        (req_we),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .resp_valid    (resp_valid),
        .resp_rdata    (resp_rdata),
        .resp_err      (resp_err),
        .bar_base      (bar_base),
        .bar_en        (bar_en),
        .range_changed (range_changed)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [2:0] sz, input logic [7:0] off,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output logic rc, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_size  = sz;
        req_addr  = off;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
        er = resp_err;
        rc = range_changed;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic        er, rc;
        int          lat;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the ports
        check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        check(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 32'h0);
        check(range_changed == 1'b0, "R1 no pulse after reset", 32'(range_changed), 32'h0);
        check(bar_en == 6'b001000, "R1 only legacy enabled", 32'(bar_en), 32'h8);

        // table walk
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].sz, VECS[i].off, VECS[i].wd, rd, er, rc, lat);
            check(lat == LAT + 1, $sformatf("R2 latency vec %0d", i), 32'(lat), 32'(LAT + 1));
            check(er == VECS[i].err, $sformatf("R%0d err vec %0d", VECS[i].rq, i),
                  32'(er), 32'(VECS[i].err));
            check(rd == VECS[i].exp, $sformatf("R%0d data vec %0d", VECS[i].rq, i),
                  rd, VECS[i].exp);
        end

        // R11 plain value stored
        access(1'b0, 3'd4, 8'h30, 32'h0, rd, er, rc, lat);
        check(rd == 32'h000C0001, "R11 rom stored as written", rd, 32'h000C0001);

        // R9 relocation pulse and decoded base
        access(1'b1, 3'd4, 8'h10, 32'h00200000, rd, er, rc, lat);
        check(rc == 1'b1, "R9 pulse on relocation", 32'(rc), 32'h1);
        @(negedge clk);
        check(range_changed == 1'b0, "R9 pulse one cycle", 32'(range_changed), 32'h0);
        check(bar_base[31:0] == 32'h00200000, "R9 bar0 base", bar_base[31:0], 32'h00200000);
        check(bar_en[0] == 1'b1, "R9 bar0 enabled", 32'(bar_en[0]), 32'h1);
        check(bar_base[63:32] == 32'h0000C0FC, "R9 bar1 io base", bar_base[63:32], 32'h0000C0FC);

        // R9 zero address part: no pulse, base kept
        access(1'b1, 3'd4, 8'h10, 32'h0000000F, rd, er, rc, lat);
        check(rc == 1'b0, "R9 no pulse on zero address", 32'(rc), 32'h0);
        @(negedge clk);
        check(bar_base[31:0] == 32'h00200000, "R9 base kept", bar_base[31:0], 32'h00200000);

        // R8 sizing never relocates
        access(1'b1, 3'd4, 8'h10, 32'hFFFFFFFF, rd, er, rc, lat);
        check(rc == 1'b0, "R8 no pulse on sizing", 32'(rc), 32'h0);

        // R10 legacy BAR
        access(1'b1, 3'd4, 8'h1C, 32'hFFFFFFFF, rd, er, rc, lat);
        check(rc == 1'b0, "R10 no pulse on legacy", 32'(rc), 32'h0);
        access(1'b0, 3'd4, 8'h1C, 32'h0, rd, er, rc, lat);
        check(rd == 32'h0, "R10 legacy reads zero", rd, 32'h0);
        check(bar_base[127:96] == 32'h000001F0, "R10 legacy base", bar_base[127:96], 32'h1F0);
        check(bar_en[3] == 1'b1, "R10 legacy enabled", 32'(bar_en[3]), 32'h1);

        // R2 ready drops while busy
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_size = 3'd4; req_addr = 8'h00;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low while busy", 32'(req_ready), 32'h0);
        repeat (LAT + 1) @(negedge clk);

        // R1 reset restores fields and enables
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bar_en == 6'b001000, "R1 enables after reset", 32'(bar_en), 32'h8);
        access(1'b0, 3'd4, 8'h3C, 32'h0, rd, er, rc, lat);
        check(rd == 32'h0804010B, "R1 int line reset", rd, 32'h0804010B);
        access(1'b0, 3'd4, 8'h10, 32'h0, rd, er, rc, lat);
        check(rd == 32'h0, "R1 bar0 reset", rd, 32'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule